// File: doc/BRIEF.md
# USB Device Suspend Power Manager

This block is the always-on power sequencer of a USB 2.0 function controller. It watches the upstream line state, interpreted for the current link speed, and counts how long the bus has been idle in 1 µs timebase ticks. A short idle spell moves the controller into a light low-power state. In that state the endpoint FIFO and the packet transmit/receive engine lose their clock enables and the bus controller switches to a slow clock. The first bus activity undoes this within one cycle, with no power sequencing.

When idle continues past the suspend threshold, the block power-gates the core domain. It asserts isolation, pulses a retention save strobe and turns the power switch off. Every step finishes well inside the hard deadline for reaching suspend current. Sustained bus activity while suspended starts the reverse sequence: switch on, wait for power-good, pulse a retention restore, drop isolation, and only then re-enable the gated clocks. The current power state is exposed as a one-hot status vector.

Top module: `usb_suspend_pm`

## Requirements
- R1: After reset the block is in the active state: both gated clock enables high, `bus_clk_slow` low, `iso_en` low, `pwr_sw_on` high, and both retention strobes low.
- R2: The idle line condition depends on `speed` (0 = low, 1 = full, 2 or 3 = high). `line_st` is {D+, D-}. Idle is `2'b01` for low speed, `2'b10` for full speed and `2'b00` for high speed. Any other value is activity.
- R3: In the active state, once the line has been idle for `GATE_US` ticks, the block enters the idle state. Both gated clock enables go low and `bus_clk_slow` goes high, while `pwr_sw_on` stays high and `iso_en` stays low.
- R4: In the idle state, a single non-idle line sample returns the block to the active state on the next clock edge. Clocks are re-enabled and the fast clock is restored, without touching the power switch.
- R5: Any non-idle sample clears the idle tick count, so idle time from before the interruption never counts toward power-down.
- R6: Power-down begins only after the idle count exceeds `SUSPEND_US` ticks, that is, on the tick numbered `SUSPEND_US`+1 of continuous idle.
- R7: Power-down runs on consecutive cycles: isolation asserted with the switch still on, then a one-cycle `ret_save` pulse with isolation held, then the switch off, then the suspended state.
- R8: The suspended state is reached before `DEADLINE_US` ticks of continuous idle have elapsed.
- R9: In suspend, fewer than `WAKE_SAMPLES` consecutive non-idle samples leave the block suspended. `WAKE_SAMPLES` consecutive non-idle samples start power-up.
- R10: Power-up order: switch on with isolation held, wait in place until `pwr_good` is high, a one-cycle `ret_restore` pulse, isolation released with clocks still gated, then the active state with clocks enabled.
- R11: `pm_state` is one-hot with bit 0 = active, bit 1 = idle, bit 2 = powering down, bit 3 = suspended, bit 4 = powering up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_st | input | 2 | Sampled upstream line state {D+, D-} |
| speed | input | 2 | Link speed: 0 low, 1 full, 2/3 high |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| pwr_good | input | 1 | Core domain supply is up |
| fifo_clk_en | output | 1 | Clock enable for the endpoint FIFO block |
| txrx_clk_en | output | 1 | Clock enable for the packet Tx/Rx engine |
| bus_clk_slow | output | 1 | Selects the slow clock for the bus controller |
| iso_en | output | 1 | Isolation of the core domain outputs |
| ret_save | output | 1 | One-cycle retention save strobe |
| ret_restore | output | 1 | One-cycle retention restore strobe |
| pwr_sw_on | output | 1 | Core domain power switch control |
| pm_state | output | 5 | One-hot power state |

## Verification
The bench builds the block with `GATE_US` = 3, `SUSPEND_US` = 30, `DEADLINE_US` = 100 and `WAKE_SAMPLES` = 2. These values put the 3 ms suspend boundary and the 10 ms deadline within a few hundred cycles. The exact tick of power-down entry can then be probed one tick either side. The idle-count reset can be exercised just short of the threshold. A one-sample glitch during suspend can be set against a genuine two-sample wake.

// File: rtl/usbpm_pkg.sv
package usbpm_pkg;

    localparam logic [1:0] SPD_LOW     = 2'd0;
    localparam logic [1:0] SPD_FULL    = 2'd1;

    localparam logic [1:0] LINE_SE0    = 2'b00;
    localparam logic [1:0] LINE_J_FULL = 2'b10;
    localparam logic [1:0] LINE_J_LOW  = 2'b01;

    typedef enum logic [4:0] {
        PM_ACTIVE = 5'b00001,
        PM_IDLE   = 5'b00010,
        PM_PDOWN  = 5'b00100,
        PM_SUSP   = 5'b01000,
        PM_PUP    = 5'b10000
    } pm_state_e;

    typedef enum logic [1:0] {
        STEP_A = 2'd0,
        STEP_B = 2'd1,
        STEP_C = 2'd2
    } seq_step_e;

    // Line value that counts as bus idle for a given speed mode
    function automatic logic [1:0] idle_pattern(input logic [1:0] spd);
        case (spd)
            SPD_LOW:  idle_pattern = LINE_J_LOW;
            SPD_FULL: idle_pattern = LINE_J_FULL;
            default:  idle_pattern = LINE_SE0;
        endcase
    endfunction

endpackage

// File: rtl/usbpm_idle_mon.sv
module usbpm_idle_mon
    import usbpm_pkg::*;
#(
    parameter int SUSPEND_US   = 3000,
    parameter int GATE_US      = 4,
    parameter int WAKE_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic [1:0] speed,
    input  logic       tick_1us,
    output logic       line_idle,
    output logic       gate_ok,
    output logic       susp_ok,
    output logic       wake_ok
);

    localparam int CNT_TOP = SUSPEND_US + 1;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam int AW      = $clog2(WAKE_SAMPLES + 1);

    typedef struct packed {
        logic [CW-1:0] idle_cnt;
        logic [AW-1:0] act_cnt;
    } mon_regs_t;

    mon_regs_t r_d, r_q;
    logic      idle_now;

    always_comb begin
        idle_now = (line_st == idle_pattern(speed));
        r_d      = r_q;

        // idle time in microseconds, saturating just past the suspend limit
        if (!idle_now) begin
            r_d.idle_cnt = '0;
        end else if (tick_1us && (r_q.idle_cnt != CW'(CNT_TOP))) begin
            r_d.idle_cnt = r_q.idle_cnt + 1'b1;
        end

        // consecutive non-idle samples, saturating at the wake count
        if (idle_now) begin
            r_d.act_cnt = '0;
        end else if (r_q.act_cnt != AW'(WAKE_SAMPLES)) begin
            r_d.act_cnt = r_q.act_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_idle = idle_now;
    assign gate_ok   = (r_q.idle_cnt >= CW'(GATE_US));
    assign susp_ok   = (r_q.idle_cnt == CW'(CNT_TOP));
    assign wake_ok   = (r_q.act_cnt == AW'(WAKE_SAMPLES));

endmodule

// File: rtl/usbpm_seq.sv
module usbpm_seq
    import usbpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_idle,
    input  logic      gate_ok,
    input  logic      susp_ok,
    input  logic      wake_ok,
    input  logic      pwr_good,
    output pm_state_e state,
    output logic      core_clk_en,
    output logic      clk_slow,
    output logic      iso,
    output logic      save,
    output logic      restore,
    output logic      sw_on
);

    typedef struct packed {
        pm_state_e st;
        seq_step_e step;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            PM_ACTIVE: begin
                if (gate_ok && line_idle) begin
                    s_d.st = PM_IDLE;
                end
            end
            PM_IDLE: begin
                if (!line_idle) begin
                    s_d.st = PM_ACTIVE;
                end else if (susp_ok) begin
                    s_d.st   = PM_PDOWN;
                    s_d.step = STEP_A;
                end
            end
            PM_PDOWN: begin
                case (s_q.step)
                    STEP_A:  s_d.step = STEP_B;
                    STEP_B:  s_d.step = STEP_C;
                    default: begin
                        s_d.st   = PM_SUSP;
                        s_d.step = STEP_A;
                    end
                endcase
            end
            PM_SUSP: begin
                if (wake_ok) begin
                    s_d.st   = PM_PUP;
                    s_d.step = STEP_A;
                end
            end
            PM_PUP: begin
                case (s_q.step)
                    STEP_A: begin
                        if (pwr_good) begin
                            s_d.step = STEP_B;
                        end
                    end
                    STEP_B:  s_d.step = STEP_C;
                    default: begin
                        s_d.st   = PM_ACTIVE;
                        s_d.step = STEP_A;
                    end
                endcase
            end
            default: begin
                s_d.st   = PM_ACTIVE;
                s_d.step = STEP_A;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PM_ACTIVE, step: STEP_A};
        end else begin
            s_q <= s_d;
        end
    end

    // output decode from registered state only
    always_comb begin
        core_clk_en = 1'b0;
        clk_slow    = 1'b1;
        iso         = 1'b0;
        save        = 1'b0;
        restore     = 1'b0;
        sw_on       = 1'b1;
        case (s_q.st)
            PM_ACTIVE: begin
                core_clk_en = 1'b1;
                clk_slow    = 1'b0;
            end
            PM_PDOWN: begin
                iso   = 1'b1;
                save  = (s_q.step == STEP_B);
                sw_on = (s_q.step != STEP_C);
            end
            PM_SUSP: begin
                iso   = 1'b1;
                sw_on = 1'b0;
            end
            PM_PUP: begin
                iso     = (s_q.step != STEP_C);
                restore = (s_q.step == STEP_B);
            end
            default: begin
                core_clk_en = 1'b0;
            end
        endcase
    end

    assign state = s_q.st;

endmodule

// File: rtl/usb_suspend_pm.sv
module usb_suspend_pm
    import usbpm_pkg::*;
#(
    parameter int GATE_US      = 4,
    parameter int SUSPEND_US   = 3000,
    parameter int DEADLINE_US  = 10000,
    parameter int WAKE_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic [1:0] speed,
    input  logic       tick_1us,
    input  logic       pwr_good,
    output logic       fifo_clk_en,
    output logic       txrx_clk_en,
    output logic       bus_clk_slow,
    output logic       iso_en,
    output logic       ret_save,
    output logic       ret_restore,
    output logic       pwr_sw_on,
    output logic [4:0] pm_state
);

    logic      line_idle, gate_ok, susp_ok, wake_ok;
    logic      core_clk_en;
    pm_state_e state;

    usbpm_idle_mon #(
        .SUSPEND_US  (SUSPEND_US),
        .GATE_US     (GATE_US),
        .WAKE_SAMPLES(WAKE_SAMPLES)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_st  (line_st),
        .speed    (speed),
        .tick_1us (tick_1us),
        .line_idle(line_idle),
        .gate_ok  (gate_ok),
        .susp_ok  (susp_ok),
        .wake_ok  (wake_ok)
    );

    usbpm_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_idle  (line_idle),
        .gate_ok    (gate_ok),
        .susp_ok    (susp_ok),
        .wake_ok    (wake_ok),
        .pwr_good   (pwr_good),
        .state      (state),
        .core_clk_en(core_clk_en),
        .clk_slow   (bus_clk_slow),
        .iso        (iso_en),
        .save       (ret_save),
        .restore    (ret_restore),
        .sw_on      (pwr_sw_on)
    );

    assign fifo_clk_en = core_clk_en;
    assign txrx_clk_en = core_clk_en;
    assign pm_state    = state;

endmodule

// File: rtl/usbpm_checker.sv
module usbpm_checker
    import usbpm_pkg::*;
#(
    parameter int SUSPEND_US  = 3000,
    parameter int DEADLINE_US = 10000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_st,
    input logic [1:0] speed,
    input logic       tick_1us,
    input logic       pwr_good,
    input logic       fifo_clk_en,
    input logic       txrx_clk_en,
    input logic       bus_clk_slow,
    input logic       iso_en,
    input logic       ret_save,
    input logic       ret_restore,
    input logic       pwr_sw_on,
    input logic [4:0] pm_state
);

    localparam int TOP = DEADLINE_US + 1;
    localparam int TW  = $clog2(TOP + 1);

    logic          quiet;
    logic [TW-1:0] run_cnt, dl_cnt;

    assign quiet = (line_st == idle_pattern(speed));

    // continuous idle time, and the same excluding time spent waking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            dl_cnt  <= '0;
        end else begin
            if (!quiet) begin
                run_cnt <= '0;
            end else if (tick_1us && run_cnt != TW'(TOP)) begin
                run_cnt <= run_cnt + 1'b1;
            end
            if (!quiet || pm_state == PM_PUP) begin
                dl_cnt <= '0;
            end else if (tick_1us && dl_cnt != TW'(TOP)) begin
                dl_cnt <= dl_cnt + 1'b1;
            end
        end
    end

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pm_state) == 1);

    p_active_clocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pm_state == PM_ACTIVE |-> fifo_clk_en && txrx_clk_en && !bus_clk_slow && pwr_sw_on && !iso_en);

    p_idle_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pm_state == PM_IDLE |-> !fifo_clk_en && !txrx_clk_en && bus_clk_slow && pwr_sw_on && !iso_en);

    p_idle_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_IDLE && !quiet) |=> (pm_state == PM_ACTIVE && fifo_clk_en && !bus_clk_slow));

    p_no_early_pdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pm_state[2]) |-> run_cnt > TW'(SUSPEND_US));

    p_save_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_save) |-> iso_en && pwr_sw_on && $past(iso_en));

    p_save_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_save |=> !ret_save);

    p_switch_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_sw_on) |-> iso_en && $past(ret_save));

    p_deadline_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dl_cnt >= TW'(DEADLINE_US) |-> pm_state == PM_SUSP);

    p_susp_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pm_state == PM_SUSP |-> !pwr_sw_on && iso_en && !fifo_clk_en && !txrx_clk_en);

    p_restore_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_restore |-> pwr_sw_on && iso_en && $past(pwr_good));

    p_iso_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> $past(ret_restore) && !fifo_clk_en && pwr_sw_on);

endmodule

bind usb_suspend_pm usbpm_checker #(
    .SUSPEND_US (SUSPEND_US),
    .DEADLINE_US(DEADLINE_US)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_st     (line_st),
    .speed       (speed),
    .tick_1us    (tick_1us),
    .pwr_good    (pwr_good),
    .fifo_clk_en (fifo_clk_en),
    .txrx_clk_en (txrx_clk_en),
    .bus_clk_slow(bus_clk_slow),
    .iso_en      (iso_en),
    .ret_save    (ret_save),
    .ret_restore (ret_restore),
    .pwr_sw_on   (pwr_sw_on),
    .pm_state    (pm_state)
);

// File: tb/usb_suspend_pm_test.sv
module usb_suspend_pm_test;

    localparam int GATE    = 3;
    localparam int SUSP    = 30;
    localparam int DLINE   = 100;
    localparam int WAKE    = 2;

    localparam logic [4:0] ST_ACT  = 5'b00001;
    localparam logic [4:0] ST_IDLE = 5'b00010;
    localparam logic [4:0] ST_PDN  = 5'b00100;
    localparam logic [4:0] ST_SUSP = 5'b01000;
    localparam logic [4:0] ST_PUP  = 5'b10000;

    // {fifo, txrx, slow, iso, save, restore, sw}
    localparam logic [6:0] O_ACT  = 7'b1100001;
    localparam logic [6:0] O_IDLE = 7'b0010001;
    localparam logic [6:0] O_SUSP = 7'b0011000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_st = 2'b01;
    logic [1:0] speed = 2'd1;
    logic       tick_1us = 1'b0;
    logic       pwr_good = 1'b1;
    logic       fifo_clk_en, txrx_clk_en, bus_clk_slow, iso_en;
    logic       ret_save, ret_restore, pwr_sw_on;
    logic [4:0] pm_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int idle_ticks = 0;

    always #4 clk = ~clk;

    usb_suspend_pm #(
        .GATE_US     (GATE),
        .SUSPEND_US  (SUSP),
        .DEADLINE_US (DLINE),
        .WAKE_SAMPLES(WAKE)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_st     (line_st),
        .speed       (speed),
        .tick_1us    (tick_1us),
        .pwr_good    (pwr_good),
        .fifo_clk_en (fifo_clk_en),
        .txrx_clk_en (txrx_clk_en),
        .bus_clk_slow(bus_clk_slow),
        .iso_en      (iso_en),
        .ret_save    (ret_save),
        .ret_restore (ret_restore),
        .pwr_sw_on   (pwr_sw_on),
        .pm_state    (pm_state)
    );

    function automatic logic [6:0] outs();
        return {fifo_clk_en, txrx_clk_en, bus_clk_slow, iso_en, ret_save, ret_restore, pwr_sw_on};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1us = 1'b1;
            @(negedge clk);
            tick_1us = 1'b0;
            cyc(3);
            idle_ticks++;
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        cyc(3);
        chk("R11 reset state code", 32'(pm_state), 32'(ST_ACT));
        chk("R1 reset outputs", 32'(outs()), 32'(O_ACT));
        rst_n = 1'b1;
        cyc(2);
        chk("R1 active after release", 32'(outs()), 32'(O_ACT));
    endtask

    task automatic test_gate_full();
        speed = 2'd1;
        line_st = 2'b10;
        run_ticks(GATE - 1);
        chk("R3 still active one tick short", 32'(pm_state), 32'(ST_ACT));
        run_ticks(1);
        chk("R3 idle state entered", 32'(pm_state), 32'(ST_IDLE));
        chk("R3 idle outputs", 32'(outs()), 32'(O_IDLE));
    endtask

    task automatic test_idle_exit();
        line_st = 2'b01;
        cyc(1);
        chk("R4 back to active next cycle", 32'(pm_state), 32'(ST_ACT));
        chk("R4 clocks and switch after exit", 32'(outs()), 32'(O_ACT));
    endtask

    task automatic test_speed_modes();
        speed = 2'd0;
        line_st = 2'b10;
        run_ticks(GATE + 5);
        chk("R2 full-speed J is not idle at low speed", 32'(pm_state), 32'(ST_ACT));
        line_st = 2'b01;
        run_ticks(GATE);
        chk("R2 low-speed idle detected", 32'(pm_state), 32'(ST_IDLE));
        speed = 2'd2;
        line_st = 2'b10;
        cyc(1);
        chk("R2 J is activity at high speed", 32'(pm_state), 32'(ST_ACT));
        line_st = 2'b00;
        run_ticks(GATE);
        chk("R2 SE0 idle at high speed", 32'(pm_state), 32'(ST_IDLE));
        line_st = 2'b01;
        cyc(1);
        chk("R2 K wakes from high-speed idle", 32'(pm_state), 32'(ST_ACT));
    endtask

    task automatic test_count_clear();
        speed = 2'd1;
        line_st = 2'b10;
        run_ticks(SUSP);
        chk("R5 idle at threshold", 32'(pm_state), 32'(ST_IDLE));
        line_st = 2'b01;
        cyc(1);
        line_st = 2'b10;
        idle_ticks = 0;
        run_ticks(SUSP);
        chk("R5 no power-down after interrupted idle", 32'(pm_state), 32'(ST_IDLE));
        chk("R5 switch still on", 32'(pwr_sw_on), 32'd1);
    endtask

    task automatic test_power_down();
        tick_1us = 1'b1;
        @(negedge clk);
        tick_1us = 1'b0;
        idle_ticks++;
        chk("R6 not yet powering down", 32'(pm_state), 32'(ST_IDLE));
        cyc(1);
        chk("R6 power-down begins", 32'(pm_state), 32'(ST_PDN));
        chk("R7 isolation first, switch on", 32'({iso_en, ret_save, pwr_sw_on}), 32'(3'b101));
        cyc(1);
        chk("R7 save pulse under isolation", 32'({iso_en, ret_save, pwr_sw_on}), 32'(3'b111));
        cyc(1);
        chk("R7 switch off after save", 32'({iso_en, ret_save, pwr_sw_on}), 32'(3'b100));
        cyc(1);
        chk("R7 suspended state", 32'(pm_state), 32'(ST_SUSP));
        chk("R7 suspend outputs", 32'(outs()), 32'(O_SUSP));
        chk("R8 suspended within deadline", 32'(idle_ticks < DLINE), 32'd1);
        run_ticks(DLINE);
        chk("R8 stays suspended on long idle", 32'(pm_state), 32'(ST_SUSP));
    endtask

    task automatic test_wake_glitch();
        line_st = 2'b01;
        cyc(1);
        line_st = 2'b10;
        cyc(4);
        chk("R9 single sample ignored", 32'(pm_state), 32'(ST_SUSP));
        chk("R9 switch stays off", 32'(pwr_sw_on), 32'd0);
    endtask

    task automatic test_power_up();
        pwr_good = 1'b0;
        line_st = 2'b01;
        cyc(2);
        chk("R9 still suspended after two samples", 32'(pm_state), 32'(ST_SUSP));
        cyc(1);
        chk("R9 power-up started", 32'(pm_state), 32'(ST_PUP));
        chk("R10 switch on, isolation held", 32'(outs()), 32'(7'b0011001));
        cyc(5);
        chk("R10 waits for power-good", 32'({pm_state, ret_restore}), 32'({ST_PUP, 1'b0}));
        pwr_good = 1'b1;
        cyc(1);
        chk("R10 restore pulse", 32'(outs()), 32'(7'b0011011));
        cyc(1);
        chk("R10 isolation released, clocks gated", 32'(outs()), 32'(7'b0010001));
        cyc(1);
        chk("R10 active with clocks", 32'(outs()), 32'(O_ACT));
        chk("R11 active code after wake", 32'(pm_state), 32'(ST_ACT));
    endtask

    initial begin
        test_reset();
        test_gate_full();
        test_idle_exit();
        test_speed_modes();
        test_count_clear();
        test_power_down();
        test_wake_glitch();
        test_power_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule